// File: doc/BRIEF.md
# Multi-Region Display RAM Address Pointer

This block keeps the address pointer a character display controller uses when the host reads or writes its memories. Three regions can be addressed: text RAM (character codes), glyph RAM (user-defined character patterns) and segment RAM (icon bits). The host sets a start address with a load strobe. After that, each completed data access moves the pointer one step up or down, as a direction input selects.

The legal address set is not one contiguous range. Each region is cut into equal power-of-two slots, and only the leading part of each slot is usable. In text RAM the slot size depends on how many display lines are active. When a step leaves the usable part of a slot, the pointer moves on to the next usable address in the next or previous slot. After the last slot it wraps to the first. The block reports whether the pointer is at a legal address and which display line it lies on. It also raises a flag when an access is made at an address in a gap between slots.

Top module: `ram_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x00, ptrValid is 1 (text RAM, one-line mode), lineIdx is 0 and gapHit is 0.
- R2: Region encoding is regionSel 00 = text, 10 = glyph, 11 = segment, 01 = reserved. A load stores loadAddr with bit 7 cleared for text, all 8 bits for glyph, and bits 7:4 cleared for segment. ptrOut always shows the stored value reduced the same way for the region currently selected. The reserved code has no legal address, and steps leave the pointer unchanged.
- R3: Text line mode uses lineMode 00 = one line (0x00–0x4F), 01 = two lines (0x00–0x27, 0x40–0x67), and 10 or 11 = four lines (0x00–0x13, 0x20–0x33, 0x40–0x53, 0x60–0x73).
- R4: In glyph RAM each of the 8 slots of 32 addresses has 26 legal addresses (offsets 0x00–0x19). Offsets 0x1A–0x1F are gaps.
- R5: Segment RAM has 16 legal addresses, 0x0–0xF, with no gaps.
- R6: With stepDown = 0, an accessDone pulse adds one inside a slot. From the last legal address of a slot the pointer moves to the first address of the next slot, and from the last slot to the first address of slot 0.
- R7: With stepDown = 1, a step subtracts one inside a slot. From the first address of a slot the pointer moves to the last legal address of the previous slot, and from slot 0 to the last legal address of the final slot.
- R8: A step taken at a gap address goes up to the first address of the next slot (wrapping), or down to the last legal address of the same slot.
- R9: loadEn takes priority over accessDone in the same cycle.
- R10: Without loadEn or accessDone, and with the region unchanged, the pointer holds.
- R11: ptrValid is 1 exactly when the pointer is at a legal address. gapHit is 1 in any cycle where accessDone is high while ptrValid is 0.
- R12: lineIdx gives the slot index in text RAM (always 0 in one-line mode) and 0 in every other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regionSel | input | 2 | Target memory region |
| lineMode | input | 2 | Active display line count for text RAM |
| stepDown | input | 1 | Step direction: 0 up, 1 down |
| loadEn | input | 1 | Load pointer from loadAddr |
| loadAddr | input | 8 | Start address to load |
| accessDone | input | 1 | One-cycle pulse marking a finished data access |
| ptrOut | output | 8 | Current pointer reduced to the selected region |
| ptrValid | output | 1 | Pointer lies at a legal address |
| lineIdx | output | 2 | Display line of the pointer in text RAM |
| gapHit | output | 1 | Access attempted at a gap address |

## Verification
The hardest states to reach from the ports are the slot boundaries after a change of line mode or region, together with gap addresses hit by a step. This matters most for the downward wrap from slot 0 and for a step taken from a gap. Directed loads place the pointer on each slot edge and inside gaps in every region and line mode. The random phase then keeps stepping while it changes the region and line mode only now and then, so long runs cross many slot edges under each geometry.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;
  localparam int PTR_W   = 8;
  localparam int SHIFT_W = $clog2(PTR_W + 1);
  localparam int LINE_W  = 2;

  typedef enum logic [1:0] {
    RGN_TEXT  = 2'b00,
    RGN_RSVD  = 2'b01,
    RGN_GLYPH = 2'b10,
    RGN_SEG   = 2'b11
  } region_e;

  // slot geometry of the selected region
  typedef struct packed {
    logic [SHIFT_W-1:0] shift;  // log2 of slot size
    logic [PTR_W-1:0]   len;    // legal addresses per slot
    logic [PTR_W-1:0]   count;  // number of slots (0 = none)
    logic [PTR_W-1:0]   mask;   // address bits kept for the region
  } geom_t;

  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
    logic touch;
  } strobe_t;
endpackage

// File: rtl/ram_ptr_ctrl.sv
module ram_ptr_ctrl
  import ram_ptr_pkg::*;
#(
  parameter int TEXT_SPACE_LOG2 = 7,
  parameter int TEXT_LEN_ONE    = 80,
  parameter int TEXT_LEN_TWO    = 40,
  parameter int TEXT_LEN_FOUR   = 20,
  parameter int GLYPH_SLOT_LOG2 = 5,
  parameter int GLYPH_LEN       = 26,
  parameter int SEG_SPACE_LOG2  = 4
) (
  input  logic [1:0] regionSel,
  input  logic [1:0] lineMode,
  input  logic       stepDown,
  input  logic       loadEn,
  input  logic       accessDone,
  output geom_t      geom,
  output strobe_t    stb,
  output logic       isText
);
  localparam int TEXT_MASK   = (1 << TEXT_SPACE_LOG2) - 1;
  localparam int GLYPH_COUNT = 1 << (PTR_W - GLYPH_SLOT_LOG2);
  localparam int SEG_MASK    = (1 << SEG_SPACE_LOG2) - 1;
  localparam int TEXT_MODES  = 3;

  geom_t textGeom [TEXT_MODES];

  // one geometry per line count: 1, 2 and 4 lines
  for (genvar g = 0; g < TEXT_MODES; g++) begin : g_text
    localparam int LEN = (g == 0) ? TEXT_LEN_ONE :
                         (g == 1) ? TEXT_LEN_TWO : TEXT_LEN_FOUR;
    assign textGeom[g] = '{
      shift: SHIFT_W'(TEXT_SPACE_LOG2 - g),
      len:   PTR_W'(LEN),
      count: PTR_W'(1 << g),
      mask:  PTR_W'(TEXT_MASK)
    };
  end

  logic [1:0] textSel;
  assign textSel = lineMode[1] ? 2'd2 : {1'b0, lineMode[0]};

  always_comb begin
    unique case (region_e'(regionSel))
      RGN_TEXT:  geom = textGeom[textSel];
      RGN_GLYPH: geom = '{shift: SHIFT_W'(GLYPH_SLOT_LOG2), len: PTR_W'(GLYPH_LEN),
                          count: PTR_W'(GLYPH_COUNT), mask: '1};
      RGN_SEG:   geom = '{shift: SHIFT_W'(SEG_SPACE_LOG2), len: PTR_W'(SEG_MASK + 1),
                          count: PTR_W'(1), mask: PTR_W'(SEG_MASK)};
      default:   geom = '{shift: '0, len: '0, count: '0, mask: '1};
    endcase
  end

  logic usable;
  assign usable = (geom.count != '0);
  assign isText = (region_e'(regionSel) == RGN_TEXT);

  always_comb begin
    stb.load  = loadEn;
    stb.touch = accessDone;
    stb.inc   = accessDone & ~loadEn & ~stepDown & usable;
    stb.dec   = accessDone & ~loadEn &  stepDown & usable;
  end
endmodule

// File: rtl/ram_ptr_dp.sv
module ram_ptr_dp
  import ram_ptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  geom_t            geom,
  input  strobe_t          stb,
  input  logic [PTR_W-1:0] loadAddr,
  output logic [PTR_W-1:0] ptrOut,
  output logic             ptrValid,
  output logic [LINE_W-1:0] winLow,
  output logic             gapHit
);
  logic [PTR_W-1:0] ptrQ, eff, offMask, off, win;
  logic [PTR_W-1:0] lastOff, winUp, winDn, nextUp, nextDn;
  logic             inWin;

  assign eff     = ptrQ & geom.mask;
  assign offMask = (PTR_W'(1) << geom.shift) - PTR_W'(1);
  assign off     = eff & offMask;
  assign win     = eff >> geom.shift;
  assign inWin   = (geom.count != '0) && (off < geom.len);
  assign lastOff = geom.len - PTR_W'(1);
  assign winUp   = (win + PTR_W'(1) >= geom.count) ? '0 : win + PTR_W'(1);
  assign winDn   = (win == '0) ? geom.count - PTR_W'(1) : win - PTR_W'(1);

  always_comb begin
    if (inWin && off < lastOff) nextUp = eff + PTR_W'(1);
    else                        nextUp = winUp << geom.shift;
  end

  always_comb begin
    if (!inWin)          nextDn = (win << geom.shift) | lastOff;
    else if (off != '0)  nextDn = eff - PTR_W'(1);
    else                 nextDn = (winDn << geom.shift) | lastOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ptrQ <= '0;
    else if (stb.load) ptrQ <= loadAddr & geom.mask;
    else if (stb.inc)  ptrQ <= nextUp;
    else if (stb.dec)  ptrQ <= nextDn;
  end

  assign ptrOut   = eff;
  assign ptrValid = inWin;
  assign winLow   = win[LINE_W-1:0];
  assign gapHit   = stb.touch & ~inWin;
endmodule

// File: rtl/ram_ptr_unit.sv
module ram_ptr_unit
  import ram_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regionSel,
  input  logic [1:0] lineMode,
  input  logic       stepDown,
  input  logic       loadEn,
  input  logic [7:0] loadAddr,
  input  logic       accessDone,
  output logic [7:0] ptrOut,
  output logic       ptrValid,
  output logic [1:0] lineIdx,
  output logic       gapHit
);
  geom_t             geom;
  strobe_t           stb;
  logic              isText;
  logic [LINE_W-1:0] winLow;

  ram_ptr_ctrl ctrl_i (
    .regionSel (regionSel),
    .lineMode  (lineMode),
    .stepDown  (stepDown),
    .loadEn    (loadEn),
    .accessDone(accessDone),
    .geom      (geom),
    .stb       (stb),
    .isText    (isText)
  );

  ram_ptr_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .geom    (geom),
    .stb     (stb),
    .loadAddr(loadAddr),
    .ptrOut  (ptrOut),
    .ptrValid(ptrValid),
    .winLow  (winLow),
    .gapHit  (gapHit)
  );

  assign lineIdx = isText ? winLow : '0;
endmodule

// File: rtl/ram_ptr_unit_chk.sv
module ram_ptr_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regionSel,
  input logic [1:0] lineMode,
  input logic       loadEn,
  input logic [7:0] loadAddr,
  input logic       accessDone,
  input logic [7:0] ptrOut,
  input logic       ptrValid,
  input logic [1:0] lineIdx,
  input logic       gapHit
);
  AST_SEG_LOAD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && regionSel == 2'b11 |=>
      regionSel != 2'b11 || ptrOut == {4'h0, $past(loadAddr[3:0])}); // R2

  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    regionSel == 2'b01 && !loadEn |=>
      regionSel != 2'b01 || ptrOut == $past(ptrOut)); // R2

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && regionSel == 2'b10 |=>
      regionSel != 2'b10 || ptrOut == $past(loadAddr)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn && !accessDone |=>
      regionSel != $past(regionSel) || ptrOut == $past(ptrOut)); // R10

  AST_STEP_STAYS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    accessDone && !loadEn && ptrValid && regionSel != 2'b01 |=>
      ptrValid || regionSel != $past(regionSel) || lineMode != $past(lineMode)); // R6

  AST_GAP_STEP_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    accessDone && !loadEn && !ptrValid && regionSel != 2'b01 |=>
      ptrValid || regionSel != $past(regionSel) || lineMode != $past(lineMode)); // R8

  AST_GAP_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    gapHit |-> accessDone && !ptrValid); // R11

  AST_LINE_OUTSIDE_TEXT: assert property (@(posedge clk) disable iff (!rstN)
    regionSel != 2'b00 || lineMode == 2'b00 |-> lineIdx == 2'd0); // R12
endmodule

bind ram_ptr_unit ram_ptr_unit_chk chk_i (.*);

// File: tb/ram_ptr_unit_tb_top.sv
module ram_ptr_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic [1:0] regionSel, lineMode;
  logic       stepDown, loadEn, accessDone;
  logic [7:0] loadAddr;
  logic [7:0] ptrOut;
  logic       ptrValid, gapHit;
  logic [1:0] lineIdx;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mPtr = 0;
  string lastTag = "R1";

  ram_ptr_unit dut_i (.*);

  function automatic int gShift(int r, int m);
    if (r == 0) return (m == 0) ? 7 : (m == 1) ? 6 : 5;
    if (r == 2) return 5;
    if (r == 3) return 4;
    return 0;
  endfunction

  function automatic int gLen(int r, int m);
    if (r == 0) return (m == 0) ? 80 : (m == 1) ? 40 : 20;
    if (r == 2) return 26;
    if (r == 3) return 16;
    return 0;
  endfunction

  function automatic int gCnt(int r, int m);
    if (r == 0) return (m == 0) ? 1 : (m == 1) ? 2 : 4;
    if (r == 2) return 8;
    if (r == 3) return 1;
    return 0;
  endfunction

  function automatic int gMask(int r);
    if (r == 0) return 'h7F;
    if (r == 3) return 'h0F;
    return 'hFF;
  endfunction

  function automatic bit mValid(int p, int r, int m);
    int a = p & gMask(r);
    if (gCnt(r, m) == 0) return 0;
    return (a % (1 << gShift(r, m))) < gLen(r, m);
  endfunction

  function automatic int mNext(int p, int r, int m, bit ld, int addr, bit acc, bit dn);
    int a, sz, win, off, len, cnt;
    if (ld) return addr & gMask(r);
    cnt = gCnt(r, m);
    if (!acc || cnt == 0) return p;
    a = p & gMask(r);
    sz = 1 << gShift(r, m);
    len = gLen(r, m);
    win = a / sz;
    off = a % sz;
    if (!dn) begin
      if (off < len - 1) return a + 1;
      return ((win + 1 == cnt) ? 0 : win + 1) * sz;
    end
    if (off >= len) return win * sz + len - 1;
    if (off > 0) return a - 1;
    return ((win == 0) ? cnt - 1 : win - 1) * sz + len - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit ld, int addr, bit acc, bit dn, int r, int m, string tag);
    int a;
    @(negedge clk);
    loadEn = ld; loadAddr = addr[7:0]; accessDone = acc; stepDown = dn;
    regionSel = r[1:0]; lineMode = m[1:0];
    #1;
    a = mPtr & gMask(r);
    chk(lastTag, ptrOut, a);
    chk("R11 valid", ptrValid, mValid(mPtr, r, m));
    chk("R11 gapHit", gapHit, acc && !mValid(mPtr, r, m));
    chk("R12 lineIdx", lineIdx, (r == 0) ? a >> gShift(r, m) : 0);
    @(posedge clk);
    mPtr = mNext(mPtr, r, m, ld, addr, acc, dn);
    lastTag = tag;
    #1;
  endtask

  task automatic expectPtr(string tag, int exp);
    chk(tag, ptrOut, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 0; regionSel = 0; lineMode = 0; stepDown = 0;
    loadEn = 0; loadAddr = 0; accessDone = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    chk("R1 ptr", ptrOut, 0);
    chk("R1 valid", ptrValid, 1);
    chk("R1 line", lineIdx, 0);
    chk("R1 gap", gapHit, 0);

    // text RAM, bit 7 dropped
    step(1, 'hC5, 0, 0, 0, 0, "R2"); expectPtr("R2 text bit7", 'h45);
    // one-line wrap
    step(1, 'h4F, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, "R6");    expectPtr("R6 one-line wrap", 'h00);
    // two lines
    step(1, 'h27, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 0, 1, "R3");    expectPtr("R3 two-line jump", 'h40);
    step(1, 'h67, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 0, 1, "R6");    expectPtr("R6 two-line wrap", 'h00);
    step(0, 0, 1, 1, 0, 1, "R7");    expectPtr("R7 two-line back wrap", 'h67);
    step(1, 'h40, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 1, 0, 1, "R7");    expectPtr("R7 two-line back", 'h27);
    // four lines
    step(1, 'h33, 0, 0, 0, 2, "R3");
    step(0, 0, 1, 0, 0, 2, "R3");    expectPtr("R3 four-line jump", 'h40);
    step(1, 'h73, 0, 0, 0, 3, "R3");
    step(0, 0, 1, 0, 0, 3, "R6");    expectPtr("R6 four-line wrap", 'h00);
    step(0, 0, 1, 1, 0, 3, "R7");    expectPtr("R7 four-line back wrap", 'h73);
    step(1, 'h15, 0, 0, 0, 2, "R3");
    step(0, 0, 1, 0, 0, 2, "R8");    expectPtr("R8 gap up", 'h20);
    step(1, 'h35, 0, 0, 0, 2, "R3");
    step(0, 0, 1, 1, 0, 2, "R8");    expectPtr("R8 gap down", 'h33);
    // glyph RAM
    step(1, 'h19, 0, 0, 2, 0, "R4");
    step(0, 0, 1, 0, 2, 0, "R4");    expectPtr("R4 glyph jump", 'h20);
    step(1, 'h1C, 0, 0, 2, 0, "R4");
    chk("R4 gap invalid", ptrValid, 0);
    step(0, 0, 1, 0, 2, 0, "R8");    expectPtr("R8 glyph gap up", 'h20);
    step(1, 'hF9, 0, 0, 2, 0, "R4");
    step(0, 0, 1, 0, 2, 0, "R6");    expectPtr("R6 glyph wrap", 'h00);
    step(0, 0, 1, 1, 2, 0, "R7");    expectPtr("R7 glyph back wrap", 'hF9);
    // segment RAM
    step(1, 'hAB, 0, 0, 3, 0, "R2"); expectPtr("R2 seg mask", 'h0B);
    step(1, 'h0F, 0, 0, 3, 0, "R5");
    step(0, 0, 1, 0, 3, 0, "R5");    expectPtr("R5 seg wrap", 'h00);
    step(0, 0, 1, 1, 3, 0, "R5");    expectPtr("R5 seg back", 'h0F);
    // load wins over step
    step(1, 'h07, 1, 0, 3, 0, "R9"); expectPtr("R9 load priority", 'h07);
    // idle hold
    step(0, 'h0C, 0, 1, 3, 0, "R10"); expectPtr("R10 idle hold", 'h07);
    // reserved region
    step(1, 'h33, 0, 0, 1, 0, "R2");
    step(0, 0, 1, 0, 1, 0, "R2");    expectPtr("R2 reserved frozen", 'h33);
    chk("R2 reserved invalid", ptrValid, 0);

    // random phase
    begin
      int r = 0, m = 0;
      for (int i = 0; i < 4000; i++) begin
        int pick = $urandom_range(0, 99);
        bit ld = ($urandom_range(0, 99) < 8);
        bit acc = ($urandom_range(0, 99) < 70);
        bit dn = ($urandom_range(0, 99) < 40);
        if (pick < 3) begin
          int q = $urandom_range(0, 9);
          r = (q < 5) ? 0 : (q < 7) ? 2 : (q < 9) ? 3 : 1;
          m = $urandom_range(0, 3);
        end
        step(ld, $urandom_range(0, 255), acc, dn, r, m,
             ld ? (acc ? "R9" : "R2") : !acc ? "R10" : dn ? "R7" : "R6");
      end
    end

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule